// File: doc/BRIEF.md
# Streaming Running Row Maximum (Van Herk)

This block applies a flat one-dimensional maximum filter of width W to a stream of grayscale pixels arriving one per clock. For every clock cycle it produces the maximum of the W most recent pixel slots, where a slot with valid low counts as a pixel of value zero. The result is the per-row term of a wide line or rectangle dilation. A later stage combines several of these row results across rows. The window width W is a parameter meant for widths from 9 to 32.

The cost is three max comparators for any W. The stream is cut into consecutive segments of W cycles. A forward running maximum restarts at the first slot of each segment. A backward running maximum is formed by reading the previous segment back in reverse order out of a W-entry buffer. That buffer alternates its write direction each segment, so one buffer serves both the write and the reversed read. The output is the larger of a backward value and a forward value. Valid, line start and line end are delayed by the same number of cycles as the data, so downstream logic can place each result in the frame.

Each line must arrive on consecutive valid cycles. Between the end of one line and the start of the next there must be at least W-1 invalid cycles. Because those blank slots count as zero, they pad each line edge with zeros, and the previous line cannot raise the maximum of the next one.

Top module: `vh_row_max`

## Requirements
- R1: While rst_n is low, and after reset until the first sampled input reaches the output, out_pix is 0 and out_valid, out_sol and out_eol are 0.
- R2: The out_pix value shown after the clock edge that samples input slot x+W+1 equals the maximum of slots x-W+1 through x. The latency is W+2 cycles, and slots before reset count as 0.
- R3: R2 holds at every alignment of the window against the internal W-cycle segments. This includes strictly rising and strictly falling runs of pixels.
- R4: A slot whose in_valid is 0 counts as pixel 0, whatever value in_pix carries in that cycle.
- R5: Consider a line that ends with in_eol and is followed by at least W-1 invalid cycles before the next in_sol. No pixel of the ending line affects out_pix for any pixel of the next line, which gives zero padding at the line edges.
- R6: out_valid, out_sol and out_eol equal in_valid, in_sol and in_eol delayed by W+2 cycles, and they stay aligned with out_pix.
- R7: A single nonzero pixel in an otherwise zero line appears on out_pix for exactly W consecutive cycles, starting W+2 cycles after it is sampled.
- R8: The full-scale values 255 and 0 of an 8-bit pixel pass through the maximum unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_pix | input | PIX_W | Input grayscale pixel |
| in_valid | input | 1 | Input pixel is valid |
| in_sol | input | 1 | Input pixel is the first of a line |
| in_eol | input | 1 | Input pixel is the last of a line |
| out_pix | output | PIX_W | Maximum over the W-slot window |
| out_valid | output | 1 | Delayed in_valid |
| out_sol | output | 1 | Delayed in_sol |
| out_eol | output | 1 | Delayed in_eol |

## Verification
The filter is driven with lines of random pixels, which exercise the general maximum. Rising and falling ramps are also used. A rising ramp makes every result come from the forward running maximum. A falling ramp makes every result come from the reversed backward maximum, so a fault in either path shows up separately. A lone impulse shows the window width and the latency, and a line with a full-scale pixel at its very end followed by exactly W-1 blank cycles shows whether the padding keeps the previous line out. Blank cycles carry random garbage on in_pix to show that invalid slots are treated as zero.

// File: rtl/vhmax_pkg.sv
package vhmax_pkg;

    // Pixel width shared by the row-maximum datapath.
    parameter int PIX_W = 8;

    typedef logic [PIX_W-1:0] pix_t;

    // Registered state of the comparator core.
    typedef struct packed {
        pix_t fwd;   // forward running maximum within the segment
        pix_t bwd;   // backward running maximum of the previous segment
        pix_t cdly;  // forward value delayed by W+1 cycles
        pix_t outp;  // registered window maximum
    } core_t;

    function automatic pix_t pix_max(input pix_t a, input pix_t b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/vh_seg_phase.sv
module vh_seg_phase #(
    parameter int W = 9,
    localparam int AW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [AW-1:0] ph,
    output logic          dir
);

    typedef struct packed {
        logic [AW-1:0] ph;
        logic          dir;
    } seg_t;

    seg_t seg_d, seg_q;

    always_comb begin
        seg_d = seg_q;
        if (seg_q.ph == AW'(W - 1)) begin
            seg_d.ph  = '0;
            seg_d.dir = ~seg_q.dir;
        end else begin
            seg_d.ph = seg_q.ph + AW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seg_q <= '0;
        end else begin
            seg_q <= seg_d;
        end
    end

    assign ph  = seg_q.ph;
    assign dir = seg_q.dir;

    // After the last slot of a segment the next segment begins at slot 0.
    AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == AW'(W - 1)) |=> (ph == '0 && dir != $past(dir))); // R3

    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (ph != AW'(W - 1)) |=> (ph == $past(ph) + AW'(1))); // R3

endmodule

// File: rtl/vh_rev_buf.sv
// W-entry buffer with read-before-write at one address per cycle.
// MODE 0: address runs forward in even segments and backward in odd ones.
// MODE 1: the opposite direction of MODE 0.
// MODE 2: address equals the slot index (a plain W-cycle delay).
module vh_rev_buf
    import vhmax_pkg::*;
#(
    parameter int W    = 9,
    parameter int MODE = 0,
    localparam int AW  = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ph,
    input  logic          dir,
    input  pix_t          wr_data,
    output pix_t          rd_data
);

    pix_t          mem_d [W];
    pix_t          mem_q [W];
    logic [AW-1:0] addr;
    logic [AW-1:0] rev;

    assign rev = AW'(W - 1) - ph;

    generate
        if (MODE == 0) begin : g_fwd_first
            assign addr = dir ? rev : ph;
        end else if (MODE == 1) begin : g_rev_first
            assign addr = dir ? ph : rev;
        end else begin : g_plain
            assign addr = ph;
        end
    endgenerate

    assign rd_data = mem_q[addr];

    always_comb begin
        mem_d       = mem_q;
        mem_d[addr] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < W; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

endmodule

// File: rtl/vh_mark_delay.sv
module vh_mark_delay #(
    parameter int DEPTH = 11,
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] sh_d [DEPTH];
    logic [WIDTH-1:0] sh_q [DEPTH];

    always_comb begin
        sh_d[0] = din;
        for (int i = 1; i < DEPTH; i++) begin
            sh_d[i] = sh_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                sh_q[i] <= '0;
            end
        end else begin
            sh_q <= sh_d;
        end
    end

    assign dout = sh_q[DEPTH-1];

endmodule

// File: rtl/vh_row_max.sv
module vh_row_max
    import vhmax_pkg::*;
#(
    parameter int W    = 9,
    localparam int AW  = $clog2(W),
    localparam int LAT = W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIX_W-1:0] in_pix,
    input  logic             in_valid,
    input  logic             in_sol,
    input  logic             in_eol,
    output logic [PIX_W-1:0] out_pix,
    output logic             out_valid,
    output logic             out_sol,
    output logic             out_eol
);

    logic [AW-1:0] ph;
    logic          dir;
    pix_t          px;
    pix_t          rd_seg;
    pix_t          rd_bwd;
    pix_t          rd_fwd;
    core_t         core_d, core_q;
    logic [2:0]    mark_out;

    // Blank slots act as zero pixels.
    assign px = in_valid ? pix_t'(in_pix) : '0;

    vh_seg_phase #(.W(W)) i_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .ph    (ph),
        .dir   (dir)
    );

    // Reversal buffer: the previous segment's pixels come out in reverse order.
    vh_rev_buf #(.W(W), .MODE(0)) i_seg_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .ph      (ph),
        .dir     (dir),
        .wr_data (px),
        .rd_data (rd_seg)
    );

    // Backward maxima are written in reverse and read back in stream order.
    vh_rev_buf #(.W(W), .MODE(1)) i_bwd_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .ph      (ph),
        .dir     (dir),
        .wr_data (core_d.bwd),
        .rd_data (rd_bwd)
    );

    // Forward maxima delayed by W cycles.
    vh_rev_buf #(.W(W), .MODE(2)) i_fwd_dly (
        .clk     (clk),
        .rst_n   (rst_n),
        .ph      (ph),
        .dir     (dir),
        .wr_data (core_d.fwd),
        .rd_data (rd_fwd)
    );

    always_comb begin
        core_d = core_q;
        // Comparator 1: forward prefix maximum.
        if (ph == '0) begin
            core_d.fwd = px;
        end else begin
            core_d.fwd = pix_max(core_q.fwd, px);
        end
        // Comparator 2: backward suffix maximum over the reversed segment.
        if (ph == '0) begin
            core_d.bwd = rd_seg;
        end else begin
            core_d.bwd = pix_max(core_q.bwd, rd_seg);
        end
        core_d.cdly = rd_fwd;
        // Comparator 3: combine suffix and prefix into the window maximum.
        core_d.outp = pix_max(rd_bwd, core_q.cdly);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    vh_mark_delay #(.DEPTH(LAT), .WIDTH(3)) i_marks (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({in_valid, in_sol, in_eol}),
        .dout  (mark_out)
    );

    assign out_pix   = core_q.outp;
    assign out_valid = mark_out[2];
    assign out_sol   = mark_out[1];
    assign out_eol   = mark_out[0];

    // Inside a segment the prefix maximum never falls.
    AST_FWD_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        (ph != '0) |=> (core_q.fwd >= $past(core_q.fwd))); // R3

    // Inside a segment the suffix maximum never falls.
    AST_BWD_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        (ph != '0) |=> (core_q.bwd >= $past(core_q.bwd))); // R3

    // Line markers on the input belong to valid pixels.
    AST_IN_MARK_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sol || in_eol) |-> in_valid); // R5

    // Delayed markers stay with a valid output slot.
    AST_OUT_MARK_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sol || out_eol) |-> out_valid); // R6

endmodule

// File: tb/test_vh_row_max.sv
module test_vh_row_max;
    import vhmax_pkg::*;

    localparam int W          = 9;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = W + 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [PIX_W-1:0] in_pix = '0;
    logic             in_valid = 1'b0;
    logic             in_sol = 1'b0;
    logic             in_eol = 1'b0;
    logic [PIX_W-1:0] out_pix;
    logic             out_valid;
    logic             out_sol;
    logic             out_eol;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 1'b0;
    string cur_req  = "R2";

    int hp[$];
    bit hv[$];
    bit hs[$];
    bit he[$];

    vh_row_max #(.W(W)) i_vh_row_max (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_pix    (in_pix),
        .in_valid  (in_valid),
        .in_sol    (in_sol),
        .in_eol    (in_eol),
        .out_pix   (out_pix),
        .out_valid (out_valid),
        .out_sol   (out_sol),
        .out_eol   (out_eol)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input string what, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s got %0d expected %0d", req, what, got, exp);
        end
    endtask

    // Compare the outputs against the sliding-window model of R2 and R6.
    task automatic check_now();
        int x;
        int m;
        x = hp.size() - W - 2;
        m = 0;
        for (int k = x - W + 1; k <= x; k++) begin
            if (k >= 0 && hp[k] > m) m = hp[k];
        end
        chk(cur_req, "out_pix", int'(out_pix), m);
        chk("R6", "out_valid", int'(out_valid), (x >= 0) ? int'(hv[x]) : 0);
        chk("R6", "out_sol",   int'(out_sol),   (x >= 0) ? int'(hs[x]) : 0);
        chk("R6", "out_eol",   int'(out_eol),   (x >= 0) ? int'(he[x]) : 0);
    endtask

    task automatic step(input int px, input bit v, input bit s, input bit e);
        @(negedge clk);
        check_now();
        in_pix   = PIX_W'(px);
        in_valid = v;
        in_sol   = s;
        in_eol   = e;
        hp.push_back(v ? px : 0);
        hv.push_back(v);
        hs.push_back(s);
        he.push_back(e);
    endtask

    // Blank cycles carry random garbage on in_pix (R4).
    task automatic blank(input int n);
        for (int i = 0; i < n; i++) step(int'($urandom_range(255, 0)), 1'b0, 1'b0, 1'b0);
    endtask

    task automatic send_line(input int pix[$]);
        for (int i = 0; i < pix.size(); i++)
            step(pix[i], 1'b1, i == 0, i == pix.size() - 1);
    endtask

    task automatic finish_test();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            finish_test();
        end
    end

    initial begin
        int line[$];
        // R1: reset state.
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R1", "out_pix in reset", int'(out_pix), 0);
            chk("R1", "markers in reset", int'({out_valid, out_sol, out_eol}), 0);
        end
        rst_n = 1'b1;

        // R2: random line.
        cur_req = "R2";
        line = {};
        for (int i = 0; i < 40; i++) line.push_back(int'($urandom_range(250, 1)));
        send_line(line);

        // R4: garbage during blanking must read as zero.
        cur_req = "R4";
        blank(W + 3);

        // R3: rising ramp (forward path) then falling ramp (backward path).
        cur_req = "R3";
        line = {};
        for (int i = 0; i < 31; i++) line.push_back(5 + 7 * i);
        send_line(line);
        blank(W - 1);
        line = {};
        for (int i = 0; i < 31; i++) line.push_back(230 - 7 * i);
        send_line(line);
        blank(W - 1);

        // R5 and R8: full scale at the line end, then exactly W-1 blank cycles.
        cur_req = "R5";
        line = {};
        for (int i = 0; i < 20; i++) line.push_back(int'($urandom_range(100, 0)));
        line.push_back(255);
        send_line(line);
        blank(W - 1);
        cur_req = "R8";
        line = {};
        for (int i = 0; i < 25; i++) line.push_back((i % 6 == 0) ? 0 : int'($urandom_range(3, 1)));
        send_line(line);
        blank(W - 1);

        // R7: a single impulse in a zero line.
        cur_req = "R7";
        line = {};
        for (int i = 0; i < 30; i++) line.push_back((i == 11) ? 200 : 0);
        send_line(line);
        blank(W - 1);

        // R2: a further random line at another segment alignment.
        cur_req = "R2";
        line = {};
        for (int i = 0; i < 17; i++) line.push_back(int'($urandom_range(255, 0)));
        send_line(line);
        blank(2 * LAT + W);

        finish_test();
    end

endmodule